// File: doc/BRIEF.md
# Serial-In Latched Parallel-Out Register

This block collects a serial bit stream into an internal shift stage and, on command, copies that stage into a holding register that drives a parallel output word. Two strobe pins control it. A shift strobe advances the stage by one bit. A latch strobe transfers the stage into the holding register. Both strobes act on their rising edge only. An active-low clear pin empties the shift stage at once and leaves the holding register as it is. An active-low enable pin controls whether the parallel word is driven. The pad is modelled as a data word plus a drive flag.

The last shift stage is brought out as a cascade bit. The serial input of a second instance can take this bit, so that longer words are built from several blocks that share the same strobes. The strobe pins and the serial data pin are asynchronous to the system clock. Each passes through a synchronizer, and an edge detector turns the strobes into single-cycle events. A strobe pulse must therefore stay high for at least three system cycles and then low for at least three system cycles.

Top module: `serlatch`

## Requirements
- R1: After reset, the shift stage and the holding register are zero, so `par_o` and `casc_o` read 0.
- R2: Each rising edge of `sclk_i` moves the shift stage one place: `par` bit 0 position (the first stage) takes `ser_i`, and stage n takes the old stage n-1. A level held high, and a falling edge, cause no shift.
- R3: A rising edge of `lclk_i` copies all WIDTH shift stages into the holding register. `par_o[n]` shows stage n, so a byte sent most significant bit first appears on `par_o` unchanged.
- R4: While `clr_ni` is low, the shift stage is forced to zero without waiting for a clock edge, so `casc_o` is low. Shift strobes have no effect during this time.
- R5: Clear has no effect on the holding register. `par_o` keeps its value until the next latch edge.
- R6: When `oe_ni` is high, `par_en_o` is 0 and the parallel word is undriven. When `oe_ni` is low, `par_en_o` is 1. `casc_o` does not depend on `oe_ni`.
- R7: `casc_o` is always the last shift stage, so two instances chained through it act as one 2*WIDTH-bit register. The first word sent ends up in the downstream instance.
- R8: When both strobes rise in the same cycle, the latch takes the shift stage as it was before that cycle's shift. With the two strobes tied together, `par_o` therefore always lags the shift stage by one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| ser_i | input | 1 | Serial data pin (asynchronous) |
| sclk_i | input | 1 | Shift strobe pin, rising edge active (asynchronous) |
| lclk_i | input | 1 | Latch strobe pin, rising edge active (asynchronous) |
| clr_ni | input | 1 | Active-low asynchronous clear of the shift stage |
| oe_ni | input | 1 | Active-low parallel output enable |
| par_o | output | WIDTH | Holding register contents (pad data) |
| par_en_o | output | 1 | Pad drive flag; 0 means high impedance |
| casc_o | output | 1 | Last shift stage, for cascading |

## Verification
The hardest case to reach is a shift edge and a latch edge that land in the same system cycle. This only happens when the two pins rise together and pass through identical synchronizer paths. The stimulus covers it by driving both pins from one task in the same cycle, both as a directed run of tied strobes and as a random operation. It also chains two instances, so a wrong cascade bit or a shift order off by one shows up in the downstream word.

// File: rtl/serlatch_pkg.sv
package serlatch_pkg;
  // bit positions in the synchronized pin vector
  localparam int unsigned PIN_SCLK = 0;
  localparam int unsigned PIN_LCLK = 1;
  localparam int unsigned PIN_SER  = 2;
  localparam int unsigned NPINS    = 3;
  localparam int unsigned NSTROBES = 2;
endpackage

// File: rtl/serlatch_sync.sv
module serlatch_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/serlatch_edge.sv
module serlatch_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/serlatch_shift.sv
module serlatch_shift #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             step_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  logic             arst_n;
  logic [WIDTH-1:0] stage_q;

  // clear shares the async path with system reset
  assign arst_n = rst_ni & clr_ni;

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else if (step_i) stage_q <= {stage_q[WIDTH-2:0], ser_i};
  end

  assign q_o = stage_q;
endmodule

// File: rtl/serlatch_hold.sv
module serlatch_hold #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/serlatch.sv
module serlatch
  import serlatch_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             sclk_i,
  input  logic             lclk_i,
  input  logic             clr_ni,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] par_o,
  output logic             par_en_o,
  output logic             casc_o
);
  logic [NPINS-1:0]    pins_raw;
  logic [NPINS-1:0]    pins_s;
  logic [NSTROBES-1:0] strobe_rise;
  logic                sclk_rise;
  logic                lclk_rise;
  logic                ser_s;
  logic [WIDTH-1:0]    shift_q;

  // data and strobes share one synchronizer so they stay aligned
  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SCLK] = sclk_i;
    pins_raw[PIN_LCLK] = lclk_i;
    pins_raw[PIN_SER]  = ser_i;
  end

  serlatch_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  serlatch_edge #(.WIDTH(NSTROBES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({pins_s[PIN_LCLK], pins_s[PIN_SCLK]}),
    .rise_o(strobe_rise)
  );

  assign sclk_rise = strobe_rise[0];
  assign lclk_rise = strobe_rise[1];
  assign ser_s     = pins_s[PIN_SER];

  serlatch_shift #(.WIDTH(WIDTH)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_ni(clr_ni),
    .step_i(sclk_rise),
    .ser_i (ser_s),
    .q_o   (shift_q)
  );

  // same-cycle strobes: holding register samples the pre-shift value
  serlatch_hold #(.WIDTH(WIDTH)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(lclk_rise),
    .d_i   (shift_q),
    .q_o   (par_o)
  );

  assign par_en_o = ~oe_ni;
  assign casc_o   = shift_q[WIDTH-1];
endmodule

// File: rtl/serlatch_chk.sv
module serlatch_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_ni,
  input logic             oe_ni,
  input logic             sclk_rise,
  input logic             lclk_rise,
  input logic             ser_s,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] par_o,
  input logic             par_en_o,
  input logic             casc_o
);
  p_shift_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    sclk_rise |=> shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_s)});

  p_latch_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lclk_rise |=> par_o == $past(shift_q));

  p_clear_casc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (casc_o == 1'b0 && shift_q == '0));

  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lclk_rise |=> $stable(par_o));

  p_drive_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !par_en_o);
endmodule

bind serlatch serlatch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_ni   (clr_ni),
  .oe_ni    (oe_ni),
  .sclk_rise(sclk_rise),
  .lclk_rise(lclk_rise),
  .ser_s    (ser_s),
  .shift_q  (shift_q),
  .par_o    (par_o),
  .par_en_o (par_en_o),
  .casc_o   (casc_o)
);

// File: tb/serlatch_tb_top.sv
`timescale 1ns/1ps
module serlatch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b0, sclk = 1'b0, lclk = 1'b0, clr_n = 1'b1, oe_n = 1'b0;
  logic [7:0] par_a, par_b;
  logic en_a, en_b, casc_a, casc_b;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] m_a = '0, m_b = '0, h_a = '0, h_b = '0;

  always #2.5 clk = ~clk;

  serlatch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .sclk_i(sclk), .lclk_i(lclk),
    .clr_ni(clr_n), .oe_ni(oe_n), .par_o(par_a), .par_en_o(en_a), .casc_o(casc_a)
  );

  serlatch dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(casc_a), .sclk_i(sclk), .lclk_i(lclk),
    .clr_ni(clr_n), .oe_ni(oe_n), .par_o(par_b), .par_en_o(en_b), .casc_o(casc_b)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " par_a"}, par_a, h_a);
    chk({req, " par_b"}, par_b, h_b);
    chk({req, " casc_a"}, {7'd0, casc_a}, {7'd0, m_a[7]});
    chk({req, " casc_b"}, {7'd0, casc_b}, {7'd0, m_b[7]});
    chk({req, " en"}, {6'd0, en_a, en_b}, {6'd0, ~oe_n, ~oe_n});
  endtask

  function automatic void model_shift(logic b);
    m_b = {m_b[6:0], m_a[7]};
    m_a = {m_a[6:0], b};
  endfunction

  task automatic pulse(logic do_s, logic do_l, logic b);
    @(negedge clk);
    ser = b;
    sclk = do_s;
    lclk = do_l;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    lclk = 1'b0;
    repeat (4) @(negedge clk);
    if (do_l) begin h_a = m_a; h_b = m_b; end
    if (do_s) model_shift(b);
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) pulse(1'b1, 1'b0, v[i]);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    chk("R4 async casc_a", {7'd0, casc_a}, 8'd0);
    // shift strobe during clear has no effect
    sclk = 1'b1;
    ser = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    m_a = '0;
    m_b = '0;
    chk("R5 hold kept a", par_a, h_a);
    chk("R5 hold kept b", par_b, h_b);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R4 after clear");
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R1 reset");

    // R7 chained bytes, R2/R3 ordering
    send_byte(8'hA5);
    send_byte(8'h3C);
    chk("R2 nothing latched yet", par_a, 8'h00);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R3 par_a", par_a, 8'h3C);
    chk("R7 par_b", par_b, 8'hA5);
    chk_all("R7 chain");

    // R2 level held high gives only one shift
    @(negedge clk);
    ser = 1'b1; sclk = 1'b1;
    repeat (20) @(negedge clk);
    sclk = 1'b0;
    repeat (20) @(negedge clk);
    model_shift(1'b1);
    pulse(1'b0, 1'b1, 1'b0);
    chk_all("R2 single shift");

    // R5/R4 clear
    do_clear();

    // R6 output enable
    send_byte(8'hC3);
    oe_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R6 disabled");
    pulse(1'b0, 1'b1, 1'b0);
    chk_all("R6 casc independent");
    oe_n = 1'b0;
    #1;
    chk_all("R6 enabled");

    // R8 tied strobes
    for (int i = 0; i < 8; i++) begin
      pulse(1'b1, 1'b1, 1'(i & 1));
      chk_all("R8 tied lag");
    end

    // random mix
    for (int i = 0; i < 80; i++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      if (op < 5) pulse(1'b1, 1'b0, 1'($urandom_range(0, 1)));
      else if (op < 7) pulse(1'b0, 1'b1, 1'b0);
      else if (op < 9) pulse(1'b1, 1'b1, 1'($urandom_range(0, 1)));
      else do_clear();
      if (op == 6) oe_n = 1'($urandom_range(0, 1));
      #1;
      chk_all("R2 R3 R8 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule